// File: doc/BRIEF.md
# Secondary Controller State Gate

This block tracks, for a set of secondary (virtual-function) storage controllers, whether each one is online or offline, and enforces that state. The management logic sends online and offline requests by controller ID and gets a status code back one cycle later. The block also keeps each secondary's assigned queue and interrupt counts, along with the pool-wide totals of both. It issues a one-cycle function-reset pulse to any secondary whose state actually changes. A primary reset or the clearing of the virtual-function enable takes every secondary offline at once.

On the register side, the block sits between a host register-access bus and the register file of the selected secondary. While a secondary is offline, every access except one to the status register is stopped before it reaches the register file, and reads return zero. On status reads the block supplies the failed flag itself. After each function reset it latches the failed flag, the usable I/O queue-pair count and the interrupt-vector count. The enable-permission signal is high only for online secondaries.

Top module: `sec_ctrl_gate`

## Requirements
- R1: After reset every secondary is offline (`sec_en_ok` = 0), its failed flag is 1, its I/O queue-pair count is 0, its vector count is 1, and both pool totals are 0.
- R2: A count load (`set_valid`) writes `set_q`/`set_i` into secondary `set_idx` and moves the pool totals by the difference. The load is ignored when that secondary is online, or when `req_valid`, `prim_reset` or `vf_off` is high in the same cycle.
- R3: Secondary index k answers to controller ID `BASE_ID`+k. A request with any other ID returns status 0x011F and changes no state.
- R4: An online request returns status 0x0120 and leaves the secondary offline unless it holds at least one interrupt and at least two queues and its `func_present` bit is set.
- R5: A successful online request returns status 0 and sets `sec_en_ok` for that secondary, with a one-cycle `sec_frst` pulse in the response cycle. An online request to a secondary that is already online returns 0 and gives no pulse.
- R6: An offline request returns 0 and zeroes the secondary's queue and interrupt counts, lowering the pool totals by the amounts it held. If the secondary was online, it goes offline and gets a `sec_frst` pulse. Otherwise no pulse is given.
- R7: `rsp_valid` is high for exactly the one cycle that follows an accepted request.
- R8: In the cycle after a `sec_frst` pulse, the secondary's failed flag equals "offline", its I/O queue-pair count equals queue count − 1 (0 when there are no queues), and its vector count equals its interrupt count (minimum 1).
- R9: For an offline selected secondary and an address other than `STS_ADDR`, `rf_rd` and `rf_wr` stay low and `host_rdata` is 0.
- R10: Accesses to `STS_ADDR` always reach the register file, and a status read returns `rf_rdata` with bit `FAIL_BIT` replaced by the secondary's failed flag. For an online secondary, other addresses pass through unchanged.
- R11: `prim_reset` or `vf_off` takes every secondary offline, zeroes all counts and both pools, and pulses `sec_frst` for each secondary that was online. A request presented in the same cycle is dropped and gets no response.
- R12: `sec_en_ok` grants controller enable only to online secondaries, so an offline secondary stays disabled.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | State request strobe |
| req_online | input | 1 | 1 = bring online, 0 = take offline |
| req_id | input | ID_W | Target controller ID |
| rsp_valid | output | 1 | Response strobe |
| rsp_status | output | 16 | Response status code |
| set_valid | input | 1 | Count load strobe |
| set_idx | input | IDX_W | Secondary index for the load |
| set_q | input | CNT_W | Queue count to load |
| set_i | input | CNT_W | Interrupt count to load |
| func_present | input | NUM_SEC | Secondary function exists |
| prim_reset | input | 1 | Primary reset pulse |
| vf_off | input | 1 | Virtual-function enable cleared pulse |
| sec_en_ok | output | NUM_SEC | Enable permitted (online) |
| sec_frst | output | NUM_SEC | Function-reset pulse per secondary |
| sec_fail | output | NUM_SEC | Latched failed flag |
| sec_ioq | output | NUM_SEC*CNT_W | Usable I/O queue pairs per secondary |
| sec_vec | output | NUM_SEC*CNT_W | Interrupt vectors per secondary |
| pool_q | output | POOL_W | Total queues assigned to secondaries |
| pool_i | output | POOL_W | Total interrupts assigned to secondaries |
| host_idx | input | IDX_W | Secondary selected by the host bus |
| host_rd | input | 1 | Host read strobe |
| host_wr | input | 1 | Host write strobe |
| host_addr | input | ADDR_W | Host register address |
| host_wdata | input | DATA_W | Host write data |
| host_rdata | output | DATA_W | Read data to the host |
| rf_rd | output | 1 | Gated read strobe to the register file |
| rf_wr | output | 1 | Gated write strobe to the register file |
| rf_addr | output | ADDR_W | Register file address |
| rf_wdata | output | DATA_W | Register file write data |
| rf_rdata | input | DATA_W | Register file read data |

## Verification
The assertions assume that the host bus holds `host_idx` below `NUM_SEC`, and that the request, load and reset pulses last one cycle and change only away from the rising edge. The bench drives every strobe on the falling edge for a single cycle and uses only indices 0 to 3. The assertions also assume that a count load targets an existing index. The bench's loads all do, and the bench checks the pool totals as running sums that it computes on its own.

// File: rtl/sgate_pkg.sv
package sgate_pkg;
  localparam logic [15:0] ST_OK        = 16'h0000;
  localparam logic [15:0] ST_BAD_ID    = 16'h011F;
  localparam logic [15:0] ST_BAD_STATE = 16'h0120;
  localparam int unsigned MIN_ONLINE_Q = 2;
endpackage

// File: rtl/sgate_state.sv
module sgate_state
  import sgate_pkg::*;
#(
  parameter int NUM_SEC = 4,
  parameter int ID_W    = 16,
  parameter int BASE_ID = 1,
  parameter int CNT_W   = 8,
  parameter int IDX_W   = 2,
  parameter int POOL_W  = 11
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     req_valid,
  input  logic                     req_online,
  input  logic [ID_W-1:0]          req_id,
  input  logic                     set_valid,
  input  logic [IDX_W-1:0]         set_idx,
  input  logic [CNT_W-1:0]         set_q,
  input  logic [CNT_W-1:0]         set_i,
  input  logic [NUM_SEC-1:0]       func_present,
  input  logic                     glob_off,
  output logic [NUM_SEC-1:0]       online,
  output logic [NUM_SEC-1:0]       frst,
  output logic                     rsp_valid,
  output logic [15:0]              rsp_status,
  output logic [NUM_SEC*CNT_W-1:0] q_flat,
  output logic [NUM_SEC*CNT_W-1:0] i_flat,
  output logic [POOL_W-1:0]        pool_q,
  output logic [POOL_W-1:0]        pool_i
);
  logic [NUM_SEC-1:0] on_r, on_n, frst_r, frst_n, hsel;
  logic [CNT_W-1:0]   q_r [NUM_SEC];
  logic [CNT_W-1:0]   q_n [NUM_SEC];
  logic [CNT_W-1:0]   i_r [NUM_SEC];
  logic [CNT_W-1:0]   i_n [NUM_SEC];
  logic [POOL_W-1:0]  pq_r, pq_n, pi_r, pi_n;
  logic               rv_r, rv_n;
  logic [15:0]        rs_r, rs_n;

  // ID decode: one-hot hit vector
  always_comb begin
    hsel = '0;
    for (int k = 0; k < NUM_SEC; k++) begin
      if (req_id == ID_W'(BASE_ID + k)) hsel[k] = 1'b1;
    end
  end

  // next-state
  always_comb begin
    on_n   = on_r;
    frst_n = '0;
    pq_n   = pq_r;
    pi_n   = pi_r;
    rv_n   = 1'b0;
    rs_n   = ST_OK;
    for (int k = 0; k < NUM_SEC; k++) begin
      q_n[k] = q_r[k];
      i_n[k] = i_r[k];
    end
    if (glob_off) begin
      on_n   = '0;
      frst_n = on_r;
      pq_n   = '0;
      pi_n   = '0;
      for (int k = 0; k < NUM_SEC; k++) begin
        q_n[k] = '0;
        i_n[k] = '0;
      end
    end else if (req_valid) begin
      rv_n = 1'b1;
      if (hsel == '0) begin
        rs_n = ST_BAD_ID;
      end
      for (int k = 0; k < NUM_SEC; k++) begin
        if (hsel[k]) begin
          if (req_online) begin
            if (!on_r[k]) begin
              if ((i_r[k] != '0) && (q_r[k] >= CNT_W'(MIN_ONLINE_Q)) && func_present[k]) begin
                on_n[k]   = 1'b1;
                frst_n[k] = 1'b1;
              end else begin
                rs_n = ST_BAD_STATE;
              end
            end
          end else begin
            pq_n      = pq_r - POOL_W'(q_r[k]);
            pi_n      = pi_r - POOL_W'(i_r[k]);
            q_n[k]    = '0;
            i_n[k]    = '0;
            on_n[k]   = 1'b0;
            frst_n[k] = on_r[k];
          end
        end
      end
    end else if (set_valid) begin
      for (int k = 0; k < NUM_SEC; k++) begin
        if ((set_idx == IDX_W'(k)) && !on_r[k]) begin
          pq_n   = pq_r - POOL_W'(q_r[k]) + POOL_W'(set_q);
          pi_n   = pi_r - POOL_W'(i_r[k]) + POOL_W'(set_i);
          q_n[k] = set_q;
          i_n[k] = set_i;
        end
      end
    end
  end

  // registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      on_r   <= '0;
      frst_r <= '0;
      pq_r   <= '0;
      pi_r   <= '0;
      rv_r   <= 1'b0;
      rs_r   <= ST_OK;
      for (int k = 0; k < NUM_SEC; k++) begin
        q_r[k] <= '0;
        i_r[k] <= '0;
      end
    end else begin
      on_r   <= on_n;
      frst_r <= frst_n;
      pq_r   <= pq_n;
      pi_r   <= pi_n;
      rv_r   <= rv_n;
      rs_r   <= rs_n;
      for (int k = 0; k < NUM_SEC; k++) begin
        q_r[k] <= q_n[k];
        i_r[k] <= i_n[k];
      end
    end
  end

  for (genvar g = 0; g < NUM_SEC; g++) begin : g_flat
    assign q_flat[g*CNT_W +: CNT_W] = q_r[g];
    assign i_flat[g*CNT_W +: CNT_W] = i_r[g];
  end

  assign online     = on_r;
  assign frst       = frst_r;
  assign rsp_valid  = rv_r;
  assign rsp_status = rs_r;
  assign pool_q     = pq_r;
  assign pool_i     = pi_r;
endmodule

// File: rtl/sgate_slot.sv
module sgate_slot #(
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             frst,
  input  logic             online,
  input  logic [CNT_W-1:0] q_cnt,
  input  logic [CNT_W-1:0] i_cnt,
  output logic             fail,
  output logic [CNT_W-1:0] ioq,
  output logic [CNT_W-1:0] vec
);
  logic             fail_r, fail_n;
  logic [CNT_W-1:0] ioq_r, ioq_n, vec_r, vec_n;

  always_comb begin
    fail_n = fail_r;
    ioq_n  = ioq_r;
    vec_n  = vec_r;
    if (frst) begin
      fail_n = !online;
      ioq_n  = (q_cnt == '0) ? '0 : q_cnt - CNT_W'(1);
      vec_n  = (i_cnt == '0) ? CNT_W'(1) : i_cnt;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      fail_r <= 1'b1;
      ioq_r  <= '0;
      vec_r  <= CNT_W'(1);
    end else if (frst) begin
      fail_r <= fail_n;
      ioq_r  <= ioq_n;
      vec_r  <= vec_n;
    end
  end

  assign fail = fail_r;
  assign ioq  = ioq_r;
  assign vec  = vec_r;
endmodule

// File: rtl/sgate_bus.sv
module sgate_bus #(
  parameter int              NUM_SEC  = 4,
  parameter int              IDX_W    = 2,
  parameter int              ADDR_W   = 12,
  parameter int              DATA_W   = 32,
  parameter logic [ADDR_W-1:0] STS_ADDR = 12'h01C,
  parameter int              FAIL_BIT = 1
) (
  input  logic [NUM_SEC-1:0] online,
  input  logic [NUM_SEC-1:0] fail,
  input  logic [IDX_W-1:0]   host_idx,
  input  logic               host_rd,
  input  logic               host_wr,
  input  logic [ADDR_W-1:0]  host_addr,
  input  logic [DATA_W-1:0]  host_wdata,
  output logic [DATA_W-1:0]  host_rdata,
  output logic               rf_rd,
  output logic               rf_wr,
  output logic [ADDR_W-1:0]  rf_addr,
  output logic [DATA_W-1:0]  rf_wdata,
  input  logic [DATA_W-1:0]  rf_rdata
);
  logic sel_on, sel_fail, is_sts, pass;

  always_comb begin
    sel_on   = 1'b0;
    sel_fail = 1'b1;
    for (int k = 0; k < NUM_SEC; k++) begin
      if (host_idx == IDX_W'(k)) begin
        sel_on   = online[k];
        sel_fail = fail[k];
      end
    end
  end

  assign is_sts = (host_addr == STS_ADDR);
  assign pass   = sel_on || is_sts;

  always_comb begin
    host_rdata = '0;
    if (pass) begin
      host_rdata = rf_rdata;
      if (is_sts) host_rdata[FAIL_BIT] = sel_fail;
    end
  end

  assign rf_rd    = host_rd && pass;
  assign rf_wr    = host_wr && pass;
  assign rf_addr  = host_addr;
  assign rf_wdata = host_wdata;
endmodule

// File: rtl/sec_ctrl_gate.sv
module sec_ctrl_gate #(
  parameter int                NUM_SEC  = 4,
  parameter int                ID_W     = 16,
  parameter int                BASE_ID  = 1,
  parameter int                CNT_W    = 8,
  parameter int                ADDR_W   = 12,
  parameter int                DATA_W   = 32,
  parameter logic [ADDR_W-1:0] STS_ADDR = 12'h01C,
  parameter int                FAIL_BIT = 1,
  localparam int               IDX_W    = (NUM_SEC > 1) ? $clog2(NUM_SEC) : 1,
  localparam int               POOL_W   = CNT_W + $clog2(NUM_SEC + 1)
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     req_valid,
  input  logic                     req_online,
  input  logic [ID_W-1:0]          req_id,
  output logic                     rsp_valid,
  output logic [15:0]              rsp_status,
  input  logic                     set_valid,
  input  logic [IDX_W-1:0]         set_idx,
  input  logic [CNT_W-1:0]         set_q,
  input  logic [CNT_W-1:0]         set_i,
  input  logic [NUM_SEC-1:0]       func_present,
  input  logic                     prim_reset,
  input  logic                     vf_off,
  output logic [NUM_SEC-1:0]       sec_en_ok,
  output logic [NUM_SEC-1:0]       sec_frst,
  output logic [NUM_SEC-1:0]       sec_fail,
  output logic [NUM_SEC*CNT_W-1:0] sec_ioq,
  output logic [NUM_SEC*CNT_W-1:0] sec_vec,
  output logic [POOL_W-1:0]        pool_q,
  output logic [POOL_W-1:0]        pool_i,
  input  logic [IDX_W-1:0]         host_idx,
  input  logic                     host_rd,
  input  logic                     host_wr,
  input  logic [ADDR_W-1:0]        host_addr,
  input  logic [DATA_W-1:0]        host_wdata,
  output logic [DATA_W-1:0]        host_rdata,
  output logic                     rf_rd,
  output logic                     rf_wr,
  output logic [ADDR_W-1:0]        rf_addr,
  output logic [DATA_W-1:0]        rf_wdata,
  input  logic [DATA_W-1:0]        rf_rdata
);
  // reset: asserted asynchronously, released on the clock
  logic [1:0] rst_sync;
  logic       rst_q_n;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync <= 2'b00;
    else        rst_sync <= {rst_sync[0], 1'b1};
  end
  assign rst_q_n = rst_sync[1];

  logic [NUM_SEC*CNT_W-1:0] q_flat, i_flat;

  sgate_state #(
    .NUM_SEC(NUM_SEC), .ID_W(ID_W), .BASE_ID(BASE_ID),
    .CNT_W(CNT_W), .IDX_W(IDX_W), .POOL_W(POOL_W)
  ) u_state (
    .clk(clk), .rst_n(rst_q_n),
    .req_valid(req_valid), .req_online(req_online), .req_id(req_id),
    .set_valid(set_valid), .set_idx(set_idx), .set_q(set_q), .set_i(set_i),
    .func_present(func_present), .glob_off(prim_reset | vf_off),
    .online(sec_en_ok), .frst(sec_frst),
    .rsp_valid(rsp_valid), .rsp_status(rsp_status),
    .q_flat(q_flat), .i_flat(i_flat),
    .pool_q(pool_q), .pool_i(pool_i)
  );

  for (genvar g = 0; g < NUM_SEC; g++) begin : g_slot
    sgate_slot #(.CNT_W(CNT_W)) u_slot (
      .clk(clk), .rst_n(rst_q_n),
      .frst(sec_frst[g]), .online(sec_en_ok[g]),
      .q_cnt(q_flat[g*CNT_W +: CNT_W]), .i_cnt(i_flat[g*CNT_W +: CNT_W]),
      .fail(sec_fail[g]),
      .ioq(sec_ioq[g*CNT_W +: CNT_W]), .vec(sec_vec[g*CNT_W +: CNT_W])
    );
  end

  sgate_bus #(
    .NUM_SEC(NUM_SEC), .IDX_W(IDX_W), .ADDR_W(ADDR_W), .DATA_W(DATA_W),
    .STS_ADDR(STS_ADDR), .FAIL_BIT(FAIL_BIT)
  ) u_bus (
    .online(sec_en_ok), .fail(sec_fail),
    .host_idx(host_idx), .host_rd(host_rd), .host_wr(host_wr),
    .host_addr(host_addr), .host_wdata(host_wdata), .host_rdata(host_rdata),
    .rf_rd(rf_rd), .rf_wr(rf_wr), .rf_addr(rf_addr), .rf_wdata(rf_wdata),
    .rf_rdata(rf_rdata)
  );
endmodule

// File: rtl/sec_ctrl_gate_chk.sv
module sec_ctrl_gate_chk #(
  parameter int                NUM_SEC  = 4,
  parameter int                ADDR_W   = 12,
  parameter int                DATA_W   = 32,
  parameter logic [ADDR_W-1:0] STS_ADDR = 12'h01C,
  parameter int                IDX_W    = 2,
  parameter int                POOL_W   = 11
) (
  input logic               clk,
  input logic               rst_n,
  input logic               req_valid,
  input logic               rsp_valid,
  input logic [15:0]        rsp_status,
  input logic               prim_reset,
  input logic               vf_off,
  input logic [NUM_SEC-1:0] sec_en_ok,
  input logic [NUM_SEC-1:0] sec_frst,
  input logic [NUM_SEC-1:0] sec_fail,
  input logic [POOL_W-1:0]  pool_q,
  input logic [POOL_W-1:0]  pool_i,
  input logic [IDX_W-1:0]   host_idx,
  input logic               host_rd,
  input logic [ADDR_W-1:0]  host_addr,
  input logic [DATA_W-1:0]  host_rdata,
  input logic               rf_rd,
  input logic               rf_wr
);
  logic sel_on, is_sts;
  always_comb begin
    sel_on = 1'b0;
    for (int k = 0; k < NUM_SEC; k++) begin
      if (host_idx == IDX_W'(k)) sel_on = sec_en_ok[k];
    end
  end
  assign is_sts = (host_addr == STS_ADDR);

  AST_RSP_AFTER_REQ: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |-> $past(req_valid)); // R7
  AST_BAD_ID_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && rsp_status == 16'h011F) |-> (sec_en_ok == $past(sec_en_ok))); // R3
  AST_FRST_ON_CHANGE: assert property (@(posedge clk) disable iff (!rst_n)
    (sec_frst & ~(sec_en_ok ^ $past(sec_en_ok))) == '0); // R5
  AST_FAIL_AFTER_FRST: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(sec_frst) & (sec_fail ^ ~$past(sec_en_ok))) == '0); // R8
  AST_NO_STROBE_OFFLINE: assert property (@(posedge clk) disable iff (!rst_n)
    (!sel_on && !is_sts) |-> (!rf_rd && !rf_wr)); // R9
  AST_ZERO_READ_OFFLINE: assert property (@(posedge clk) disable iff (!rst_n)
    (host_rd && !sel_on && !is_sts) |-> (host_rdata == '0)); // R9
  AST_GLOBAL_OFFLINE: assert property (@(posedge clk) disable iff (!rst_n)
    $past(prim_reset || vf_off) |-> (sec_en_ok == '0 && pool_q == '0 && pool_i == '0)); // R11
endmodule

bind sec_ctrl_gate sec_ctrl_gate_chk #(
  .NUM_SEC(NUM_SEC), .ADDR_W(ADDR_W), .DATA_W(DATA_W),
  .STS_ADDR(STS_ADDR), .IDX_W(IDX_W), .POOL_W(POOL_W)
) u_chk (.*);

// File: tb/sec_ctrl_gate_bench.sv
module sec_ctrl_gate_bench;
  logic        clk, rst_n;
  logic        req_valid, req_online;
  logic [15:0] req_id;
  logic        rsp_valid;
  logic [15:0] rsp_status;
  logic        set_valid;
  logic [1:0]  set_idx;
  logic [7:0]  set_q, set_i;
  logic [3:0]  func_present;
  logic        prim_reset, vf_off;
  logic [3:0]  sec_en_ok, sec_frst, sec_fail;
  logic [31:0] sec_ioq, sec_vec;
  logic [10:0] pool_q, pool_i;
  logic [1:0]  host_idx;
  logic        host_rd, host_wr;
  logic [11:0] host_addr, rf_addr;
  logic [31:0] host_wdata, host_rdata, rf_wdata, rf_rdata;
  logic        rf_rd, rf_wr;

  int n_chk = 0, n_bad = 0;
  bit done = 0;

  sec_ctrl_gate u_sec_ctrl_gate (.*);

  initial clk = 1'b0;
  always #4 clk = ~clk;

  task automatic chk(input string tag, input longint act, input longint exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic pulse_req(input bit on, input int id);
    req_valid = 1'b1; req_online = on; req_id = 16'(id);
    @(negedge clk);
    req_valid = 1'b0;
  endtask

  task automatic load(input int idx, input int q, input int i);
    set_valid = 1'b1; set_idx = 2'(idx); set_q = 8'(q); set_i = 8'(i);
    @(negedge clk);
    set_valid = 1'b0;
  endtask

  function automatic int ioq_of(int k); return int'(sec_ioq[k*8 +: 8]); endfunction
  function automatic int vec_of(int k); return int'(sec_vec[k*8 +: 8]); endfunction

  task automatic t_reset();
    chk("R1 en_ok", sec_en_ok, 0);
    chk("R1 fail", sec_fail, 4'hF);
    chk("R1 ioq", sec_ioq, 0);
    chk("R1 vec", sec_vec, 32'h01010101);
    chk("R1 pool_q", pool_q, 0);
    chk("R1 pool_i", pool_i, 0);
    chk("R12 disabled at reset", sec_en_ok[0], 0);
  endtask

  task automatic t_load();
    load(0, 4, 2); chk("R2 pool_q a", pool_q, 4); chk("R2 pool_i a", pool_i, 2);
    load(1, 1, 1); load(2, 3, 0); load(3, 2, 1);
    chk("R2 pool_q b", pool_q, 10); chk("R2 pool_i b", pool_i, 4);
    load(3, 2, 1); chk("R2 reload same", pool_q, 10);
  endtask

  task automatic t_bad_id();
    pulse_req(1, 9);
    chk("R3 status", rsp_status, 16'h011F); chk("R7 valid", rsp_valid, 1);
    chk("R3 no change", sec_en_ok, 0);
    @(negedge clk); chk("R7 one cycle", rsp_valid, 0);
    pulse_req(1, 0); chk("R3 id0", rsp_status, 16'h011F);
  endtask

  task automatic t_online_fail();
    pulse_req(1, 2); chk("R4 few queues", rsp_status, 16'h0120);
    pulse_req(1, 3); chk("R4 no irq", rsp_status, 16'h0120);
    pulse_req(1, 4); chk("R4 no func", rsp_status, 16'h0120);
    chk("R4 still offline", sec_en_ok, 0);
    chk("R12 offline disabled", sec_en_ok[3], 0);
  endtask

  task automatic t_online_ok();
    pulse_req(1, 1);
    chk("R5 status", rsp_status, 0); chk("R5 en_ok", sec_en_ok, 4'b0001);
    chk("R5 frst", sec_frst, 4'b0001);
    @(negedge clk);
    chk("R5 frst one cycle", sec_frst, 0);
    chk("R8 fail", sec_fail[0], 0); chk("R8 ioq", ioq_of(0), 3); chk("R8 vec", vec_of(0), 2);
    pulse_req(1, 1);
    chk("R5 repeat status", rsp_status, 0); chk("R5 repeat no frst", sec_frst, 0);
    load(0, 7, 7); chk("R2 ignored online", pool_q, 10);
    set_valid = 1'b1; set_idx = 2'd1; set_q = 8'd9; set_i = 8'd9;
    req_valid = 1'b1; req_online = 1'b1; req_id = 16'd9;
    @(negedge clk);
    set_valid = 1'b0; req_valid = 1'b0;
    chk("R2 ignored with req", pool_q, 10);
  endtask

  task automatic t_gate();
    rf_rdata = 32'hFFFF_FFF5; host_idx = 2'd1; host_addr = 12'h020; host_rd = 1'b1;
    #1;
    chk("R9 rd blocked", rf_rd, 0); chk("R9 rdata zero", host_rdata, 0);
    host_rd = 1'b0; host_wr = 1'b1; #1;
    chk("R9 wr blocked", rf_wr, 0);
    host_addr = 12'h01C; #1;
    chk("R10 sts wr passes", rf_wr, 1);
    host_wr = 1'b0; host_rd = 1'b1; #1;
    chk("R10 sts rd", rf_rd, 1); chk("R10 sts fail bit", host_rdata, 32'hFFFF_FFF7);
    host_idx = 2'd0; host_addr = 12'h020; rf_rdata = 32'hA5A5_0F0F; #1;
    chk("R10 online rd", rf_rd, 1); chk("R10 online data", host_rdata, 32'hA5A5_0F0F);
    host_addr = 12'h01C; rf_rdata = 32'hFFFF_FFFF; #1;
    chk("R10 online sts", host_rdata, 32'hFFFF_FFFD);
    host_rd = 1'b0;
    @(negedge clk);
  endtask

  task automatic t_offline();
    pulse_req(0, 1);
    chk("R6 status", rsp_status, 0); chk("R6 en_ok", sec_en_ok, 0);
    chk("R6 frst", sec_frst, 4'b0001);
    chk("R6 pool_q", pool_q, 6); chk("R6 pool_i", pool_i, 2);
    @(negedge clk);
    chk("R8 fail off", sec_fail[0], 1); chk("R8 ioq off", ioq_of(0), 0); chk("R8 vec off", vec_of(0), 1);
    pulse_req(0, 2);
    chk("R6 offline idle status", rsp_status, 0); chk("R6 no frst", sec_frst, 0);
    chk("R6 pool_q b", pool_q, 5); chk("R6 pool_i b", pool_i, 1);
  endtask

  task automatic t_global();
    load(0, 2, 1); chk("R2 pool after", pool_q, 7);
    pulse_req(1, 1); chk("R5 online again", sec_en_ok, 4'b0001);
    prim_reset = 1'b1; req_valid = 1'b1; req_online = 1'b1; req_id = 16'd3;
    @(negedge clk);
    prim_reset = 1'b0; req_valid = 1'b0;
    chk("R11 en_ok", sec_en_ok, 0); chk("R11 frst", sec_frst, 4'b0001);
    chk("R11 pool_q", pool_q, 0); chk("R11 pool_i", pool_i, 0);
    chk("R11 req dropped", rsp_valid, 0);
    load(2, 2, 1); func_present = 4'b0111;
    pulse_req(1, 3); chk("R5 idx2 on", sec_en_ok, 4'b0100);
    vf_off = 1'b1;
    @(negedge clk);
    vf_off = 1'b0;
    chk("R11 vf_off en_ok", sec_en_ok, 0); chk("R11 vf_off frst", sec_frst, 4'b0100);
    @(negedge clk);
    chk("R8 fail after vf_off", sec_fail, 4'hF);
  endtask

  initial begin
    rst_n = 1'b0; req_valid = 0; req_online = 0; req_id = 0;
    set_valid = 0; set_idx = 0; set_q = 0; set_i = 0;
    func_present = 4'b0111; prim_reset = 0; vf_off = 0;
    host_idx = 0; host_rd = 0; host_wr = 0; host_addr = 0; host_wdata = 0; rf_rdata = 0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    t_reset();
    t_load();
    t_bad_id();
    t_online_fail();
    t_online_ok();
    t_gate();
    t_offline();
    t_global();
    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end
endmodule